// File: doc/BRIEF.md
# Shift-and-Invert Execute Unit

This unit executes the register form of a bitwise-NOT instruction. It accepts the instruction in one of three encodings: a 32-bit word with a condition field, a 16-bit compact form, and a 32-bit compact form whose shift amount is split across two fields. It decodes the source and destination indices, applies an immediate shift or rotate to the source value, and inverts the result. The destination write, and optionally an update of the N, Z and C flags, are presented one clock after issue. The register file, condition evaluation, branching and exception-return handling belong to the surrounding pipeline.

A small state machine holds the outcome of the last issued operation. `ST_IDLE` means nothing was issued. `ST_SQUASH` means the word did not match or its condition failed. `ST_WRITE` means a register write without flags. `ST_WRITE_FLAGS` means a register write with a flag update. `ST_PC_WRITE` means the destination is the program counter. On every cycle the next state is chosen from the inputs alone. With no issue the next state is `ST_IDLE`. Otherwise the checks run in this order, and the first that applies wins: no match or a failed condition goes to `ST_SQUASH`; a PC destination goes to `ST_PC_WRITE`; a write with flag setting goes to `ST_WRITE_FLAGS`; anything else goes to `ST_WRITE`. The outputs are decoded from the state. The N, Z and C flag registers keep their value until the next flag update.

Top module: `shinv_exec`

## Requirements
- R1: With `form_i`=0, the word matches only when bits 31:28 differ from 1111, bits 27:21 equal 0001111 and bit 4 is 0. S is bit 20, Rd is bits 15:12, the shift amount is bits 11:7, the shift type is bits 6:5 and Rm is bits 3:0. A non-matching word, or `form_i`=3, produces no write, no PC write and no flag update.
- R2: With `form_i`=1, bits 15:6 must equal 0100001111. Rm is bits 5:3 and Rd is bits 2:0. No shift is applied, and flags are set only when `in_cblock_i` is 0.
- R3: With `form_i`=2, bits 31:21 must equal 11101010011 and bits 19:16 must equal 1111. S is bit 20, Rd is bits 11:8, the shift type is bits 5:4 and Rm is bits 3:0. The shift amount is bits 14:12 followed by bits 7:6.
- R4: Shift type 00 is a left shift. An amount of 0 leaves the value unchanged and keeps the incoming carry. Otherwise the carry is the last bit shifted out.
- R5: Shift types 01 (logical right) and 10 (arithmetic right) treat an amount of 0 as a shift by 32. The carry is the last bit shifted out.
- R6: Shift type 11 with a non-zero amount rotates right. The carry is bit 31 of the rotated value.
- R7: Shift type 11 with an amount of 0 rotates right by one through carry: `carry_i` enters bit 31 and source bit 0 becomes the carry.
- R8: `wdata_o` is the bitwise inverse of the shifted source. `wr_en_o` pulses for one cycle, one clock after issue, with `dst_idx_o` giving Rd.
- R9: When flags are set, N takes result bit 31, Z is 1 for an all-zero result and C takes the shifter carry. Without a flag update, the flag outputs hold their value.
- R10: In the 32-bit conditional form, Rd=15 raises `pc_wr_o` instead of `wr_en_o` and suppresses any flag update.
- R11: When `cond_ok_i` is 0, there is no write, no PC write and no flag update.
- R12: `unpred_o` is raised with the write in two cases: in the split form when Rd or Rm equals 15 or bit 15 is 1, and in the conditional form when bits 19:16 are not 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| issue_i | input | 1 | Instruction issued this cycle |
| form_i | input | 2 | Encoding: 0 conditional 32-bit, 1 compact 16-bit, 2 split 32-bit |
| insn_i | input | 32 | Instruction word (16-bit form in bits 15:0) |
| cond_ok_i | input | 1 | Condition check passed |
| in_cblock_i | input | 1 | Instruction lies inside a conditional block |
| src_val_i | input | XLEN | Value of the source register |
| carry_i | input | 1 | Current carry flag |
| src_idx_o | output | 4 | Decoded source index (combinational) |
| dst_idx_o | output | 4 | Destination index |
| wdata_o | output | XLEN | Result |
| wr_en_o | output | 1 | Register write enable |
| pc_wr_o | output | 1 | Result goes to the program counter |
| unpred_o | output | 1 | Unpredictable encoding |
| flag_we_o | output | 1 | Flags updated this cycle |
| flag_n_o | output | 1 | N flag |
| flag_z_o | output | 1 | Z flag |
| flag_c_o | output | 1 | C flag |

## Verification
The bench builds the unit with the default `XLEN`=32. This makes every shift amount from 0 to 31 reachable, along with the implicit shift by 32 and the carry taken from bits 0 and 31. Random words in all three forms, some with a flipped bit, exercise matching and the should-be-zero fields. Directed cases cover right shifts by 32, the rotate through carry, PC destinations and index 15 in the split form.

// File: rtl/shinv_pkg.sv
package shinv_pkg;

    localparam int REG_W = 4;
    localparam int AMT_W = 5;

    typedef enum logic [1:0] {
        FORM_COND32 = 2'd0,
        FORM_SHORT  = 2'd1,
        FORM_SPLIT  = 2'd2,
        FORM_NONE   = 2'd3
    } form_e;

    typedef enum logic [2:0] {
        SK_LSL,
        SK_LSR,
        SK_ASR,
        SK_ROR,
        SK_RRX
    } shift_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQUASH,
        ST_WRITE,
        ST_WRITE_FLAGS,
        ST_PC_WRITE
    } exec_state_e;

    typedef struct packed {
        logic             match;
        logic             setflags;
        logic             pc_dest;
        logic             unpred;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rm;
        shift_kind_e      kind;
        logic [AMT_W-1:0] amt;
    } decode_t;

    function automatic shift_kind_e kind_of(input logic [1:0] stype,
                                            input logic [AMT_W-1:0] amt);
        shift_kind_e k;
        unique case (stype)
            2'b00:   k = SK_LSL;
            2'b01:   k = SK_LSR;
            2'b10:   k = SK_ASR;
            default: k = (amt == '0) ? SK_RRX : SK_ROR;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/shinv_decode.sv
module shinv_decode
    import shinv_pkg::*;
(
    input  logic [1:0]  form_i,
    input  logic [31:0] insn_i,
    input  logic        in_cblock_i,
    output decode_t     dec_o
);

    logic [1:0]       stype;
    logic [AMT_W-1:0] amt;

    always_comb begin
        dec_o = '0;
        stype = 2'b00;
        amt   = '0;
        unique case (form_e'(form_i))
            FORM_COND32: begin
                dec_o.match    = (insn_i[31:28] != 4'hF) && (insn_i[27:21] == 7'b0001111)
                                 && !insn_i[4];
                dec_o.rd       = insn_i[15:12];
                dec_o.rm       = insn_i[3:0];
                amt            = insn_i[11:7];
                stype          = insn_i[6:5];
                dec_o.pc_dest  = (insn_i[15:12] == 4'hF);
                dec_o.setflags = insn_i[20] && (insn_i[15:12] != 4'hF);
                dec_o.unpred   = (insn_i[19:16] != 4'h0);
            end
            FORM_SHORT: begin
                dec_o.match    = (insn_i[15:6] == 10'b0100001111);
                dec_o.rd       = {1'b0, insn_i[2:0]};
                dec_o.rm       = {1'b0, insn_i[5:3]};
                dec_o.setflags = !in_cblock_i;
            end
            FORM_SPLIT: begin
                dec_o.match    = (insn_i[31:21] == 11'b11101010011) && (insn_i[19:16] == 4'hF);
                dec_o.rd       = insn_i[11:8];
                dec_o.rm       = insn_i[3:0];
                amt            = {insn_i[14:12], insn_i[7:6]};
                stype          = insn_i[5:4];
                dec_o.setflags = insn_i[20];
                dec_o.unpred   = insn_i[15] || (insn_i[11:8] == 4'hF) || (insn_i[3:0] == 4'hF);
            end
            default: begin
                dec_o.match = 1'b0;
            end
        endcase
        dec_o.amt  = amt;
        dec_o.kind = kind_of(stype, amt);
    end

endmodule

// File: rtl/shinv_shifter.sv
module shinv_shifter
    import shinv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  val_i,
    input  shift_kind_e      kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             cin_i,
    output logic [XLEN-1:0]  val_o,
    output logic             cout_o
);

    int n_ab;
    int n_rt;

    always_comb begin
        n_ab   = (amt_i == '0) ? XLEN : int'(amt_i);
        n_rt   = XLEN - int'(amt_i);
        val_o  = val_i;
        cout_o = cin_i;
        unique case (kind_i)
            SK_LSL: begin
                if (amt_i != '0) begin
                    val_o  = val_i << amt_i;
                    cout_o = val_i[n_rt];
                end
            end
            SK_LSR: begin
                val_o  = (n_ab >= XLEN) ? '0 : (val_i >> n_ab);
                cout_o = val_i[n_ab-1];
            end
            SK_ASR: begin
                val_o  = (n_ab >= XLEN) ? {XLEN{val_i[XLEN-1]}}
                                        : XLEN'($signed(val_i) >>> n_ab);
                cout_o = val_i[n_ab-1];
            end
            SK_ROR: begin
                val_o  = (val_i >> amt_i) | (val_i << n_rt);
                cout_o = val_o[XLEN-1];
            end
            default: begin
                val_o  = {cin_i, val_i[XLEN-1:1]};
                cout_o = val_i[0];
            end
        endcase
    end

endmodule

// File: rtl/shinv_exec.sv
module shinv_exec
    import shinv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            issue_i,
    input  logic [1:0]      form_i,
    input  logic [31:0]     insn_i,
    input  logic            cond_ok_i,
    input  logic            in_cblock_i,
    input  logic [XLEN-1:0] src_val_i,
    input  logic            carry_i,
    output logic [3:0]      src_idx_o,
    output logic [3:0]      dst_idx_o,
    output logic [XLEN-1:0] wdata_o,
    output logic            wr_en_o,
    output logic            pc_wr_o,
    output logic            unpred_o,
    output logic            flag_we_o,
    output logic            flag_n_o,
    output logic            flag_z_o,
    output logic            flag_c_o
);

    decode_t         dec;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] result;
    logic            sh_carry;
    exec_state_e     state_q, state_d;
    logic [3:0]      dst_q;
    logic [XLEN-1:0] data_q;
    logic            unpred_q;
    logic            fn_q, fz_q, fc_q;

    shinv_decode u_decode (
        .form_i      (form_i),
        .insn_i      (insn_i),
        .in_cblock_i (in_cblock_i),
        .dec_o       (dec)
    );

    shinv_shifter #(.XLEN(XLEN)) u_shifter (
        .val_i  (src_val_i),
        .kind_i (dec.kind),
        .amt_i  (dec.amt),
        .cin_i  (carry_i),
        .val_o  (shifted),
        .cout_o (sh_carry)
    );

    assign result    = ~shifted;
    assign src_idx_o = dec.rm;

    always_comb begin
        if (!issue_i)                         state_d = ST_IDLE;
        else if (!dec.match || !cond_ok_i)    state_d = ST_SQUASH;
        else if (dec.pc_dest)                 state_d = ST_PC_WRITE;
        else if (dec.setflags)                state_d = ST_WRITE_FLAGS;
        else                                  state_d = ST_WRITE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            dst_q    <= '0;
            data_q   <= '0;
            unpred_q <= 1'b0;
            fn_q     <= 1'b0;
            fz_q     <= 1'b0;
            fc_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d inside {ST_WRITE, ST_WRITE_FLAGS, ST_PC_WRITE}) begin
                dst_q    <= dec.rd;
                data_q   <= result;
                unpred_q <= dec.unpred;
            end
            if (state_d == ST_WRITE_FLAGS) begin
                fn_q <= result[XLEN-1];
                fz_q <= (result == '0);
                fc_q <= sh_carry;
            end
        end
    end

    always_comb begin
        wr_en_o   = 1'b0;
        pc_wr_o   = 1'b0;
        flag_we_o = 1'b0;
        unpred_o  = 1'b0;
        unique case (state_q)
            ST_WRITE: begin
                wr_en_o  = 1'b1;
                unpred_o = unpred_q;
            end
            ST_WRITE_FLAGS: begin
                wr_en_o   = 1'b1;
                flag_we_o = 1'b1;
                unpred_o  = unpred_q;
            end
            ST_PC_WRITE: begin
                pc_wr_o  = 1'b1;
                unpred_o = unpred_q;
            end
            default: ;
        endcase
    end

    assign dst_idx_o = dst_q;
    assign wdata_o   = data_q;
    assign flag_n_o  = fn_q;
    assign flag_z_o  = fz_q;
    assign flag_c_o  = fc_q;

    p_pc_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_wr_o |-> (!wr_en_o && !flag_we_o));

    p_cond_fail_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && !cond_ok_i) |=> (!wr_en_o && !pc_wr_o && !flag_we_o));

    p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_we_o |-> ($stable(flag_n_o) && $stable(flag_z_o) && $stable(flag_c_o)));

    p_zero_tracks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_we_o |-> (flag_z_o == (wdata_o == '0)));

    p_no_idle_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |=> (!wr_en_o && !pc_wr_o));

endmodule

// File: tb/shinv_exec_tb.sv
module shinv_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [1:0]  form = 2'd0;
    logic [31:0] insn = '0;
    logic        cond_ok = 1'b1;
    logic        in_cb = 1'b0;
    logic [31:0] src = '0;
    logic        cin = 1'b0;
    logic [3:0]  src_idx, dst_idx;
    logic [31:0] wdata;
    logic        wr_en, pc_wr, unpred, flag_we, fn, fz, fc;

    int errors = 0;
    int checks = 0;
    logic en = 0, ez = 0, ec = 0;

    always #5 clk = ~clk;

    shinv_exec dut_i (
        .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .form_i(form), .insn_i(insn),
        .cond_ok_i(cond_ok), .in_cblock_i(in_cb), .src_val_i(src), .carry_i(cin),
        .src_idx_o(src_idx), .dst_idx_o(dst_idx), .wdata_o(wdata), .wr_en_o(wr_en),
        .pc_wr_o(pc_wr), .unpred_o(unpred), .flag_we_o(flag_we),
        .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc)
    );

    typedef struct {
        bit       m, sf, pc, up;
        bit [3:0] rd, rm;
        bit [1:0] st;
        bit [4:0] amt;
    } ref_t;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic ref_t ref_dec(input bit [1:0] f, input bit [31:0] w, input bit cb);
        ref_t r = '{default:0};
        if (f == 2'd0) begin
            r.m = (w[31:28] != 4'hF) && (w[27:21] == 7'b0001111) && (w[4] == 1'b0);
            r.rd = w[15:12]; r.rm = w[3:0]; r.amt = w[11:7]; r.st = w[6:5];
            r.pc = (r.rd == 4'd15);
            r.sf = w[20] && !r.pc;
            r.up = (w[19:16] != 0);
        end else if (f == 2'd1) begin
            r.m = (w[15:6] == 10'b0100001111);
            r.rd = {1'b0, w[2:0]}; r.rm = {1'b0, w[5:3]};
            r.sf = !cb;
        end else if (f == 2'd2) begin
            r.m = (w[31:21] == 11'b11101010011) && (w[19:16] == 4'hF);
            r.rd = w[11:8]; r.rm = w[3:0]; r.amt = {w[14:12], w[7:6]}; r.st = w[5:4];
            r.sf = w[20];
            r.up = w[15] || (r.rd == 4'd15) || (r.rm == 4'd15);
        end
        return r;
    endfunction

    function automatic bit [32:0] ref_shift(input bit [1:0] st, input bit [4:0] amt,
                                            input bit [31:0] x, input bit c);
        bit [63:0] t;
        int n;
        n = (amt == 0) ? 32 : int'(amt);
        case (st)
            2'b00: begin
                if (amt == 0) return {c, x};
                t = {32'd0, x} << amt;
                return {t[32], t[31:0]};
            end
            2'b01: begin
                t = {x, 32'd0} >> n;
                return {t[31], t[63:32]};
            end
            2'b10: begin
                t = $signed({x, 32'd0}) >>> n;
                return {t[31], t[63:32]};
            end
            default: begin
                if (amt == 0) return {x[0], c, x[31:1]};
                t = {x, x} >> amt;
                return {t[31], t[31:0]};
            end
        endcase
    endfunction

    function automatic string shtag(input bit [1:0] st, input bit [4:0] amt);
        if (st == 2'b00) return "R4";
        if (st != 2'b11) return "R5";
        return (amt == 0) ? "R7" : "R6";
    endfunction

    function automatic string formtag(input bit [1:0] f);
        if (f == 2'd1) return "R2";
        if (f == 2'd2) return "R3";
        return "R1";
    endfunction

    function automatic bit [31:0] w_cond(bit [3:0] cc, bit s, bit [3:0] rd, bit [4:0] a,
                                         bit [1:0] st, bit [3:0] rm);
        return {cc, 7'b0001111, s, 4'b0000, rd, a, st, 1'b0, rm};
    endfunction

    function automatic bit [31:0] w_short(bit [2:0] rm, bit [2:0] rd);
        return {16'h0000, 10'b0100001111, rm, rd};
    endfunction

    function automatic bit [31:0] w_split(bit s, bit [3:0] rd, bit [4:0] a, bit [1:0] st,
                                          bit [3:0] rm);
        return {11'b11101010011, s, 4'hF, 1'b0, a[4:2], rd, a[1:0], st, rm};
    endfunction

    task automatic do_op(input bit [1:0] f, input bit [31:0] w, input bit cok,
                         input bit cb, input bit [31:0] x, input bit c);
        ref_t r;
        bit [32:0] sh;
        bit [31:0] res;
        bit wr_e, pc_e, fl_e;
        r = ref_dec(f, w, cb);
        sh = ref_shift(r.st, r.amt, x, c);
        res = ~sh[31:0];
        issue = 1'b1; form = f; insn = w; cond_ok = cok; in_cb = cb; src = x; cin = c;
        #1;
        if (r.m) chk(src_idx == r.rm, formtag(f), src_idx, r.rm);
        @(posedge clk);
        @(negedge clk);
        issue = 1'b0;
        wr_e = r.m && cok && !r.pc;
        pc_e = r.m && cok && r.pc;
        fl_e = wr_e && r.sf;
        chk(wr_en == wr_e, cok ? formtag(f) : "R11", wr_en, wr_e);
        chk(pc_wr == pc_e, "R10", pc_wr, pc_e);
        chk(flag_we == fl_e, (f == 2'd1) ? "R2" : "R9", flag_we, fl_e);
        if (wr_e || pc_e) begin
            chk(dst_idx == r.rd, "R8", dst_idx, r.rd);
            chk(wdata == res, shtag(r.st, r.amt), wdata, res);
            chk(unpred == r.up, "R12", unpred, r.up);
        end
        if (fl_e) begin
            en = res[31]; ez = (res == 0); ec = sh[32];
        end
        chk({fn, fz, fc} == {en, ez, ec}, "R9", {fn, fz, fc}, {en, ez, ec});
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk({wr_en, pc_wr, flag_we, fn, fz, fc} == 6'b0, "R8", {wr_en, pc_wr, flag_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: logical right by 32, arithmetic right by 32
        do_op(0, w_cond(4'h0, 1, 4'd2, 5'd0, 2'b01, 4'd3), 1, 0, 32'h8000_0000, 0);
        do_op(0, w_cond(4'h1, 1, 4'd2, 5'd0, 2'b10, 4'd3), 1, 0, 32'h8000_0001, 0);
        // R7: rotate through carry
        do_op(2, w_split(1, 4'd4, 5'd0, 2'b11, 4'd5), 1, 0, 32'h0000_0001, 1);
        // R6: rotate by 4
        do_op(2, w_split(1, 4'd4, 5'd4, 2'b11, 4'd5), 1, 0, 32'h0000_000F, 0);
        // R4: left shift by zero keeps carry
        do_op(0, w_cond(4'hE, 1, 4'd1, 5'd0, 2'b00, 4'd7), 1, 0, 32'h1234_5678, 1);
        do_op(0, w_cond(4'hE, 1, 4'd1, 5'd31, 2'b00, 4'd7), 1, 0, 32'h0000_0003, 0);
        // R10: PC destination with S set
        do_op(0, w_cond(4'hE, 1, 4'd15, 5'd1, 2'b00, 4'd7), 1, 0, 32'hFFFF_FFFF, 0);
        // R11: condition failed
        do_op(0, w_cond(4'hE, 1, 4'd3, 5'd1, 2'b00, 4'd7), 0, 0, 32'h0, 0);
        // R12: index 15 in split form, nonzero bits 19:16 in conditional form
        do_op(2, w_split(0, 4'd15, 5'd2, 2'b01, 4'd1), 1, 0, 32'hABCD_0000, 0);
        do_op(2, w_split(0, 4'd2, 5'd2, 2'b01, 4'd15), 1, 0, 32'hABCD_0000, 0);
        do_op(0, w_cond(4'hE, 0, 4'd3, 5'd1, 2'b10, 4'd7) | 32'h0005_0000, 1, 0, 32'h5, 0);
        // R2: inside and outside conditional block
        do_op(1, w_short(3'd6, 3'd5), 1, 1, 32'hFFFF_FFFF, 1);
        do_op(1, w_short(3'd6, 3'd5), 1, 0, 32'hFFFF_FFFF, 1);
        // R1: condition 1111 and reserved form do not match
        do_op(0, w_cond(4'hF, 1, 4'd3, 5'd1, 2'b00, 4'd7), 1, 0, 32'h1, 0);
        do_op(3, w_cond(4'hE, 1, 4'd3, 5'd1, 2'b00, 4'd7), 1, 0, 32'h1, 0);

        for (int i = 0; i < 400; i++) begin
            bit [1:0]  f  = 2'($urandom % 3);
            bit [31:0] w;
            bit [31:0] x  = $urandom;
            bit [4:0]  a  = 5'($urandom);
            if (($urandom % 4) == 0) a = 0;
            case (f)
                2'd0:    w = w_cond(4'($urandom % 15), 1'($urandom), 4'($urandom), a,
                                    2'($urandom), 4'($urandom));
                2'd1:    w = w_short(3'($urandom), 3'($urandom));
                default: w = w_split(1'($urandom), 4'($urandom), a, 2'($urandom),
                                     4'($urandom));
            endcase
            if (($urandom % 10) == 0) w[$urandom % 32] ^= 1'b1;
            if (($urandom % 8) == 0) x = ($urandom % 2) ? 32'hFFFF_FFFF : 32'h0;
            if (($urandom % 20) == 0) f = 2'd3;
            do_op(f, w, ($urandom % 8) != 0, 1'($urandom), x, 1'($urandom));
            if (($urandom % 5) == 0) begin
                @(negedge clk);
                chk(!wr_en && !pc_wr && !flag_we, "R8", {wr_en, pc_wr}, 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule